// File: doc/BRIEF.md
# Floating-Point Exception Status and Control Register

This block is a 32-bit status and control register that sits next to a floating-point unit. On every executed FPU operation it takes a strobe and a six-bit vector of exception indications: unimplemented operation, inexact, underflow, divide-by-zero, overflow and invalid operation. From these it keeps two kinds of record. Per-operation cause bits show what the most recent operation raised. Sticky flags collect the exceptions whose trap was masked.

For five of the exceptions the register also holds trap enable bits. When an operation raises an exception whose enable is set, the block emits a trap request. It also holds a denormal-flush control bit and a two-bit rounding-mode field, and drives both straight out to the arithmetic unit. Software reads the whole word and writes it through a plain write-enable port. The arithmetic, trap vectoring and pipeline control belong to other blocks.

Bits are described in two ways. Each field has a register position "b" numbered from the most significant end, so b0 is data bit 31 and b31 is data bit 0. The Verilog index of each field is given in brackets.

Top module: `fpu_exc_csr`

## Requirements
- R1: After reset the register reads 32'h0000_0100. Only the denormal-flush bit is set. `round_mode` is 0, `flush_denorm` is 1 and `trap_req` is 0.
- R2: Software writes load and read back the control fields, and the control outputs follow them.
  - Trap enables: inexact at b17 [14], underflow at b18 [13], divide-by-zero at b19 [12], overflow at b20 [11], invalid at b21 [10].
  - Denormal flush at b23 [8], driven on `flush_denorm`.
  - Rounding mode at b30..b31 [1:0], driven on `round_mode`.
- R3: The summary bit at b0 [31] reads as the OR of the underflow, divide-by-zero, overflow and invalid sticky flags. The inexact flag does not contribute. Writes to the summary bit have no effect.
- R4: The sticky flags are inexact at b1 [30], underflow at b2 [29], divide-by-zero at b3 [28], overflow at b4 [27] and invalid at b5 [26]. A flag becomes 1 on an operation that raises its exception while its enable is 0. It then holds 1 until software writes 0 to it.
- R5: An operation that raises any exception whose enable is 1 produces `trap_req` high for exactly the one cycle after the strobe edge. The sticky flags of the trapped exceptions stay unchanged.
- R6: The cause bits are unimplemented at b24 [7], inexact at b25 [6], underflow at b26 [5], divide-by-zero at b27 [4], overflow at b28 [3] and invalid at b29 [2].
  - Each operation strobe loads all six cause bits with that operation's exception vector, so the bits of absent exceptions clear.
  - Software writes do not change the cause bits.
- R7: Bits b6..b16 [25:15] and b22 [9] always read 0, whatever is written to them.
- R8: If a software write clears a sticky flag in the same cycle that an operation sets it, the flag ends up 1.
- R9: While `op_valid` is 0, `exc_in` has no effect. Cause bits, sticky flags and `trap_req` are unchanged.
- R10: The unimplemented-operation exception only sets its cause bit. It has no sticky flag, no enable bit and never requests a trap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Software write strobe |
| wr_data | input | 32 | Software write data |
| rd_data | output | 32 | Current register value |
| op_valid | input | 1 | An FPU operation completed this cycle |
| exc_in | input | 6 | Exception vector of the operation: [0] unimplemented, [1] inexact, [2] underflow, [3] divide-by-zero, [4] overflow, [5] invalid |
| trap_req | output | 1 | One-cycle trap request |
| round_mode | output | 2 | Rounding-mode field |
| flush_denorm | output | 1 | Treat denormal operands as zero |

## Verification
The assertions assume that `exc_in` carries meaning only in cycles where `op_valid` is high. They also assume that software writes and operation strobes reach the block already aligned to the clock, with no ordering between them beyond the same-cycle collision rule.

The bench drives every input on the falling edge and holds it for exactly one rising edge. This keeps strobes single-cycle and keeps values stable around the sampling edge. When the bench drives garbage on `exc_in`, it does so with the strobe low, to exercise the masking rule.

// File: rtl/fpu_csr_pkg.sv
package fpu_csr_pkg;
  localparam int XLEN      = 32;
  localparam int NUM_EXC   = 6;               // incl. unimplemented
  localparam int NUM_STK   = NUM_EXC - 1;     // exceptions with flag/enable
  localparam int RM_W      = 2;
  localparam int POS_SUM   = XLEN - 1;        // b0
  localparam int POS_STK0  = XLEN - 2;        // b1, flag j at POS_STK0-j
  localparam int POS_EN0   = XLEN - 18;       // b17, enable j at POS_EN0-j
  localparam int POS_DN    = XLEN - 24;       // b23
  localparam int POS_CAUSE0 = XLEN - 25;      // b24, cause i at POS_CAUSE0-i
  localparam logic [XLEN-1:0] RESET_VAL = 32'h0000_0100;
endpackage

// File: rtl/fpu_csr_sticky.sv
module fpu_csr_sticky
  import fpu_csr_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [NUM_STK-1:0] wr_flags,
  input  logic [NUM_STK-1:0] set_flags,
  output logic [NUM_STK-1:0] flags
);
  for (genvar j = 0; j < NUM_STK; j++) begin : g_flag
    logic q, d, ce;
    always_comb begin
      ce = wr_en | set_flags[j];
      d  = set_flags[j] ? 1'b1 : wr_flags[j];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= 1'b0;
      else if (ce) q <= d;
    end
    assign flags[j] = q;
  end
endmodule

// File: rtl/fpu_csr_ctrl.sv
module fpu_csr_ctrl
  import fpu_csr_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [NUM_STK-1:0] wr_en_bits,
  input  logic               wr_dn,
  input  logic [RM_W-1:0]    wr_rm,
  output logic [NUM_STK-1:0] enables,
  output logic               dn,
  output logic [RM_W-1:0]    rm
);
  logic [NUM_STK-1:0] en_q, en_d;
  logic               dn_q, dn_d;
  logic [RM_W-1:0]    rm_q, rm_d;

  always_comb begin
    en_d = wr_en_bits;
    dn_d = wr_dn;
    rm_d = wr_rm;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= '0;
      dn_q <= RESET_VAL[POS_DN];
      rm_q <= '0;
    end else if (wr_en) begin
      en_q <= en_d;
      dn_q <= dn_d;
      rm_q <= rm_d;
    end
  end

  assign enables = en_q;
  assign dn      = dn_q;
  assign rm      = rm_q;
endmodule

// File: rtl/fpu_csr_event.sv
module fpu_csr_event
  import fpu_csr_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               op_valid,
  input  logic [NUM_EXC-1:0] exc_in,
  input  logic [NUM_STK-1:0] enables,
  output logic [NUM_STK-1:0] set_flags,
  output logic [NUM_EXC-1:0] cause,
  output logic               trap
);
  logic [NUM_EXC-1:0] cause_q, cause_d;
  logic               trap_q, trap_d;
  logic [NUM_STK-1:0] raised;

  always_comb begin
    raised    = op_valid ? exc_in[NUM_EXC-1:1] : '0;
    set_flags = raised & ~enables;
    trap_d    = |(raised & enables);
    cause_d   = exc_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cause_q <= '0;
    else if (op_valid) cause_q <= cause_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) trap_q <= 1'b0;
    else        trap_q <= trap_d;
  end

  assign cause = cause_q;
  assign trap  = trap_q;
endmodule

// File: rtl/fpu_exc_csr.sv
module fpu_exc_csr
  import fpu_csr_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [31:0]     wr_data,
  output logic [31:0]     rd_data,
  input  logic            op_valid,
  input  logic [5:0]      exc_in,
  output logic            trap_req,
  output logic [1:0]      round_mode,
  output logic            flush_denorm
);
  logic [NUM_STK-1:0] wr_flags, wr_ens, flags, enables, set_flags;
  logic [NUM_EXC-1:0] cause;
  logic               dn;
  logic [RM_W-1:0]    rm;
  logic               unused_wr;

  always_comb begin
    for (int j = 0; j < NUM_STK; j++) begin
      wr_flags[j] = wr_data[POS_STK0-j];
      wr_ens[j]   = wr_data[POS_EN0-j];
    end
  end
  assign unused_wr = ^{wr_data[POS_SUM], wr_data[25:15], wr_data[9], wr_data[7:2]};

  fpu_csr_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_en_bits(wr_ens),
    .wr_dn(wr_data[POS_DN]), .wr_rm(wr_data[RM_W-1:0]),
    .enables(enables), .dn(dn), .rm(rm)
  );

  fpu_csr_event u_event (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .exc_in(exc_in),
    .enables(enables), .set_flags(set_flags), .cause(cause), .trap(trap_req)
  );

  fpu_csr_sticky u_sticky (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_flags(wr_flags),
    .set_flags(set_flags), .flags(flags)
  );

  always_comb begin
    rd_data = '0;
    rd_data[POS_SUM] = |flags[NUM_STK-1:1];
    for (int j = 0; j < NUM_STK; j++) begin
      rd_data[POS_STK0-j] = flags[j];
      rd_data[POS_EN0-j]  = enables[j];
    end
    rd_data[POS_DN] = dn;
    for (int i = 0; i < NUM_EXC; i++) rd_data[POS_CAUSE0-i] = cause[i];
    rd_data[RM_W-1:0] = rm;
  end

  assign round_mode   = rm;
  assign flush_denorm = dn;
endmodule

// File: rtl/fpu_exc_csr_chk.sv
module fpu_exc_csr_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en,
  input logic [31:0] rd_data,
  input logic        op_valid,
  input logic [5:0]  exc_in,
  input logic        trap_req
);
  logic [5:0] cause_rd;
  assign cause_rd = {rd_data[2], rd_data[3], rd_data[4], rd_data[5], rd_data[6], rd_data[7]};

  p_summary_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[31] == (|rd_data[29:26]));
  p_reserved_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[25:15] == '0 && rd_data[9] == 1'b0);
  p_trap_raise_r5: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && (|(exc_in[5:1] & {rd_data[10], rd_data[11], rd_data[12], rd_data[13], rd_data[14]}))
    |=> trap_req);
  p_trap_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |=> !trap_req);
  p_cause_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid |=> cause_rd == $past(exc_in));
  p_cause_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |=> $stable(cause_rd));
  p_sticky_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[26] && !wr_en |=> rd_data[26]);
  p_hw_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && exc_in[5] && !rd_data[10] |=> rd_data[26]);
endmodule

bind fpu_exc_csr fpu_exc_csr_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_data(rd_data),
  .op_valid(op_valid), .exc_in(exc_in), .trap_req(trap_req)
);

// File: tb/fpu_exc_csr_tb_top.sv
module fpu_exc_csr_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        op_valid = 1'b0;
  logic [5:0]  exc_in = '0;
  logic        trap_req;
  logic [1:0]  round_mode;
  logic        flush_denorm;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  fpu_exc_csr dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .op_valid(op_valid), .exc_in(exc_in), .trap_req(trap_req),
    .round_mode(round_mode), .flush_denorm(flush_denorm)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one clock: inputs set at negedge, sampled 1 ns after the rising edge
  task automatic step(input logic w, input logic [31:0] d, input logic v, input logic [5:0] e);
    @(negedge clk);
    wr_en = w; wr_data = d; op_valid = v; exc_in = e;
    @(posedge clk); #1;
    wr_en = 1'b0; op_valid = 1'b0; exc_in = '0;
  endtask

  task automatic t_reset();
    check("R1 rd_data", rd_data, 32'h0000_0100);
    check("R1 round_mode", {30'd0, round_mode}, 32'd0);
    check("R1 flush_denorm", {31'd0, flush_denorm}, 32'd1);
    check("R1 trap_req", {31'd0, trap_req}, 32'd0);
  endtask

  task automatic t_ctrl_fields();
    step(1, 32'h0000_7C02, 0, 0);
    check("R2 readback", rd_data, 32'h0000_7C02);
    check("R2 round_mode", {30'd0, round_mode}, 32'd2);
    check("R2 flush_denorm", {31'd0, flush_denorm}, 32'd0);
    step(1, 32'hFFFF_FFFF, 0, 0);
    check("R7 all-ones write", rd_data, 32'hFC00_7D03);
    step(1, 32'h0000_0000, 0, 0);
    check("R3 summary not writable", rd_data, 32'h0000_0000);
  endtask

  task automatic t_sticky();
    step(0, 0, 1, 6'b000100);
    check("R4 underflow sticky", rd_data, 32'hA000_0020);
    check("R4 no trap when masked", {31'd0, trap_req}, 32'd0);
    step(0, 0, 1, 6'b000000);
    check("R6 cause cleared, R4 flag holds", rd_data, 32'hA000_0000);
    step(1, 32'h0000_00FC, 0, 0);
    check("R6 cause read-only, R4 software clear", rd_data, 32'h0000_0000);
    step(0, 0, 1, 6'b000010);
    check("R3 inexact excluded from summary", rd_data, 32'h4000_0040);
    step(1, 0, 0, 0);
  endtask

  task automatic t_trap();
    step(1, 32'h0000_0800, 0, 0);
    step(0, 0, 1, 6'b010000);
    check("R5 trap asserted", {31'd0, trap_req}, 32'd1);
    check("R5 no sticky on trap", rd_data, 32'h0000_0808);
    step(0, 0, 0, 0);
    check("R5 trap one cycle", {31'd0, trap_req}, 32'd0);
    step(0, 0, 1, 6'b110000);
    check("R5 mixed trap", {31'd0, trap_req}, 32'd1);
    check("R5 masked sibling sticks", rd_data, 32'h8400_080C);
  endtask

  task automatic t_collide();
    step(1, 32'h0000_0000, 1, 6'b100000);
    check("R8 hw set wins", rd_data, 32'h8400_0004);
  endtask

  task automatic t_idle();
    step(0, 0, 0, 6'b111111);
    check("R9 exc ignored without strobe", rd_data, 32'h8400_0004);
    check("R9 no trap", {31'd0, trap_req}, 32'd0);
  endtask

  task automatic t_unimpl();
    step(1, 32'h0000_7C00, 0, 0);
    step(0, 0, 1, 6'b000001);
    check("R10 unimplemented cause only", rd_data, 32'h0000_7C80);
    check("R10 no trap", {31'd0, trap_req}, 32'd0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_ctrl_fields();
    t_sticky();
    t_trap();
    t_collide();
    t_idle();
    t_unimpl();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule